// File: doc/BRIEF.md
# Fused Multi-Operand Single-Precision Adder

This block adds K single-precision floating-point operands in one pass. It does not chain two-input adders. It finds the largest exponent among the normal operands and shifts every significand right to that common scale. Each aligned significand becomes a 32-bit two's-complement term, and the terms are reduced in carry-save form. A single carry-propagate adder closes the sum. Normalization and rounding happen once, on that final value.

The 32-bit working word has these fields:

| Field | Bits | Width |
|---|---|---|
| Sign | 31 | 1 |
| Headroom | 30..27 | 4 |
| Significand, with the hidden one at bit 26 | 26..3 | 24 |
| Fractional guard bits | 2..0 | 3 |

The four headroom bits keep a sum of up to 16 terms from overflowing. The guard bits hold the bits that alignment shifts below the significand. Bits shifted past the guard field are dropped. No sticky bit is kept.

A vector is presented with `in_valid`. The result appears exactly one clock later.

Top module: `fpc_add_cluster`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge, and `result` and `flags` hold the sum of that vector. When `in_valid` is low, `out_valid` falls and `result`/`flags` keep their previous values. Reset clears `out_valid`, `result` and `flags` to zero.
- R2: Each normal operand's 24-bit significand (hidden one restored) is shifted right by the largest normal exponent minus its own exponent. Bits below the 3-bit guard field are discarded. A difference of 27 or more contributes nothing.
- R3: The signed terms are summed exactly in the 32-bit word. Four operands with the largest significand and equal exponents sum without overflow.
- R4: A nonzero magnitude is normalized so its leading one sits at the hidden position.
  - A leading one above that position gives a right shift of up to 4 and raises the exponent by the same amount.
  - A leading one below it gives a left shift and lowers the exponent by the shift.
  - The result sign is the sign of the signed sum.
- R5: Rounding is directed away from zero. If any of the 3 guard bits after normalization is set, the magnitude is incremented by one unit in the last place and the inexact flag `flags[0]` is set.
- R6: If rounding carries out of the 24-bit significand, the significand becomes 1.0 and the exponent rises by one.
- R7: A sum of exactly zero yields +0 (0x00000000) with all flags clear.
- R8: Any NaN operand (exponent 255, fraction nonzero), or the presence of both +infinity and -infinity, yields 0x7FC00000 with only the NaN flag `flags[4]` set.
- R9: Otherwise, any infinity operand yields an infinity of that sign with only `flags[3]` set.
- R10: A final exponent of 255 or more yields a signed infinity with `flags[3]` and the overflow flag `flags[2]` set. `flags[0]` reports any rounding.
- R11: A final exponent of 0 or below yields a zero with the result sign and the underflow flag `flags[1]` set.
- R12: Operands with exponent 0 (zeros and subnormals) contribute nothing and do not take part in the exponent maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand vector present this cycle |
| op_bus | input | 32*K | K packed single-precision operands; operand i in bits [32i+31:32i] |
| out_valid | output | 1 | `result` and `flags` were updated by the previous edge |
| result | output | 32 | Packed single-precision sum |
| flags | output | 5 | Status flags: [4] NaN, [3] infinity, [2] overflow, [1] underflow, [0] inexact |

## Verification
The properties assume the following about the inputs:
- `in_valid` and `op_bus` are never unknown at a clock edge.
- The number of operands is the elaborated K, between 2 and 16, so the four headroom bits cannot wrap.

The stimulus uses only the default K of four. It drives each vector for exactly one cycle, between falling edges, and holds `in_valid` low between vectors, except where the hold behaviour itself is under test. Operand values are chosen at the edges of the scheme: growth past the hidden position, cancellation, rounding carry-out, overflow and underflow, subnormals, and each special class. Random vectors keep exponents within a narrow band so that alignment, cancellation and rounding all occur often.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int GRD_W  = 3;
    localparam int OVF_W  = 4;
    localparam int ACC_W  = 1 + OVF_W + SIG_W + GRD_W;
    localparam int MAG_W  = ACC_W - 1;
    localparam int HID_POS = GRD_W + FRAC_W;
    localparam int LP_W   = $clog2(MAG_W);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic [EXP_W-1:0] EXP_TOP = {EXP_W{1'b1}};
    localparam logic [WORD_W-1:0] QNAN_WORD = 32'h7FC0_0000;

    typedef struct packed {
        logic               sgn;
        logic [EXP_W-1:0]   exp;
        logic [FRAC_W-1:0]  frac;
    } fp_word_t;

    typedef struct packed {
        logic nan;
        logic inf;
        logic ovf;
        logic unf;
        logic inx;
    } fpc_flags_t;

    function automatic logic is_norm(input logic [EXP_W-1:0] e);
        return (e != '0) && (e != EXP_TOP);
    endfunction

endpackage

// File: rtl/fpc_max_exp.sv
module fpc_max_exp
    import fpc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N*EXP_W-1:0] exps,
    output logic [EXP_W-1:0]   emax
);
    localparam int LEAVES = 2 ** $clog2(N);

    logic [EXP_W-1:0] node [1:2*LEAVES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign node[LEAVES+i] = exps[i*EXP_W +: EXP_W];
        end else begin : g_pad
            assign node[LEAVES+i] = '0;
        end
    end

    for (genvar j = LEAVES - 1; j >= 1; j--) begin : g_cmp
        assign node[j] = (node[2*j] > node[2*j+1]) ? node[2*j] : node[2*j+1];
    end

    assign emax = node[1];
endmodule

// File: rtl/fpc_align.sv
module fpc_align
    import fpc_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    input  logic [EXP_W-1:0]  emax,
    output logic [ACC_W-1:0]  term
);
    fp_word_t          w;
    logic [EXP_W-1:0]  diff;
    logic [MAG_W-1:0]  ext;
    logic [MAG_W-1:0]  shifted;
    logic [ACC_W-1:0]  pos;

    always_comb begin
        w       = fp_word_t'(op);
        diff    = emax - w.exp;
        ext     = MAG_W'({1'b1, w.frac, {GRD_W{1'b0}}});
        shifted = (diff >= EXP_W'(HID_POS + 1)) ? '0 : (ext >> diff);
        if (!is_norm(w.exp)) begin
            shifted = '0;
        end
        pos  = {1'b0, shifted};
        term = w.sgn ? (~pos + ACC_W'(1)) : pos;
    end
endmodule

// File: rtl/fpc_csa_sum.sv
module fpc_csa_sum
    import fpc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N*ACC_W-1:0] terms,
    output logic [ACC_W-1:0]   total
);
    logic [ACC_W-1:0] s_row [0:N-1];
    logic [ACC_W-1:0] c_row [0:N-1];

    assign s_row[0] = terms[0 +: ACC_W];
    assign c_row[0] = '0;

    for (genvar i = 1; i < N; i++) begin : g_csa
        logic [ACC_W-1:0] t;
        assign t        = terms[i*ACC_W +: ACC_W];
        assign s_row[i] = s_row[i-1] ^ c_row[i-1] ^ t;
        assign c_row[i] = ((s_row[i-1] & c_row[i-1]) |
                           (s_row[i-1] & t) |
                           (c_row[i-1] & t)) << 1;
    end

    assign total = s_row[N-1] + c_row[N-1];
endmodule

// File: rtl/fpc_norm_round.sv
module fpc_norm_round
    import fpc_pkg::*;
(
    input  logic [ACC_W-1:0]  total,
    input  logic [EXP_W-1:0]  emax,
    output logic [WORD_W-1:0] word,
    output fpc_flags_t        fl
);
    logic                neg;
    logic [MAG_W-1:0]    m;
    logic [LP_W-1:0]     lp;
    logic [HID_POS:0]    nrm;
    logic [SIG_W:0]      rsig;
    logic [FRAC_W-1:0]   frac_f;
    logic signed [10:0]  e_pre;
    logic signed [10:0]  e_fin;

    always_comb begin
        neg = total[ACC_W-1];
        m   = neg ? (~total[MAG_W-1:0] + MAG_W'(1)) : total[MAG_W-1:0];
        lp  = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (m[i]) lp = LP_W'(i);
        end
        e_pre = $signed({3'b000, emax}) + $signed({{(11-LP_W){1'b0}}, lp})
                - 11'sd26;
        if (lp >= LP_W'(HID_POS)) begin
            nrm = (HID_POS+1)'(m >> (lp - LP_W'(HID_POS)));
        end else begin
            nrm = (HID_POS+1)'(m << (LP_W'(HID_POS) - lp));
        end
        fl      = '0;
        fl.inx  = |nrm[GRD_W-1:0];
        rsig    = {1'b0, nrm[HID_POS:GRD_W]} + {{SIG_W{1'b0}}, fl.inx};
        if (rsig[SIG_W]) begin
            frac_f = rsig[FRAC_W:1];
            e_fin  = e_pre + 11'sd1;
        end else begin
            frac_f = rsig[FRAC_W-1:0];
            e_fin  = e_pre;
        end
        if (m == '0) begin
            word = '0;
            fl   = '0;
        end else if (e_fin >= 11'sd255) begin
            word   = {neg, EXP_TOP, {FRAC_W{1'b0}}};
            fl.inf = 1'b1;
            fl.ovf = 1'b1;
        end else if (e_fin <= 11'sd0) begin
            word   = {neg, {(WORD_W-1){1'b0}}};
            fl.unf = 1'b1;
        end else begin
            word = {neg, e_fin[EXP_W-1:0], frac_f};
        end
    end
endmodule

// File: rtl/fpc_add_cluster.sv
module fpc_add_cluster
    import fpc_pkg::*;
#(
    parameter int K = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [K*32-1:0] op_bus,
    output logic            out_valid,
    output logic [31:0]     result,
    output logic [4:0]      flags
);
    logic [K*EXP_W-1:0]  exp_masked;
    logic [K*ACC_W-1:0]  terms;
    logic [EXP_W-1:0]    emax;
    logic [ACC_W-1:0]    total;
    logic [WORD_W-1:0]   dp_word;
    fpc_flags_t          dp_fl;
    logic                any_nan;
    logic                pos_inf;
    logic                neg_inf;
    logic [WORD_W-1:0]   nxt_word;
    fpc_flags_t          nxt_fl;

    for (genvar g = 0; g < K; g++) begin : g_op
        fp_word_t w;
        assign w = fp_word_t'(op_bus[g*WORD_W +: WORD_W]);
        assign exp_masked[g*EXP_W +: EXP_W] = is_norm(w.exp) ? w.exp : '0;

        fpc_align u_align (
            .op   (op_bus[g*WORD_W +: WORD_W]),
            .emax (emax),
            .term (terms[g*ACC_W +: ACC_W])
        );
    end

    fpc_max_exp #(.N(K)) u_max (
        .exps (exp_masked),
        .emax (emax)
    );

    fpc_csa_sum #(.N(K)) u_sum (
        .terms (terms),
        .total (total)
    );

    fpc_norm_round u_norm (
        .total (total),
        .emax  (emax),
        .word  (dp_word),
        .fl    (dp_fl)
    );

    always_comb begin
        any_nan = 1'b0;
        pos_inf = 1'b0;
        neg_inf = 1'b0;
        for (int i = 0; i < K; i++) begin
            if (op_bus[i*WORD_W+FRAC_W +: EXP_W] == EXP_TOP) begin
                if (op_bus[i*WORD_W +: FRAC_W] != '0) begin
                    any_nan = 1'b1;
                end else if (op_bus[i*WORD_W+WORD_W-1]) begin
                    neg_inf = 1'b1;
                end else begin
                    pos_inf = 1'b1;
                end
            end
        end
        nxt_fl = '0;
        if (any_nan || (pos_inf && neg_inf)) begin
            nxt_word   = QNAN_WORD;
            nxt_fl.nan = 1'b1;
        end else if (pos_inf || neg_inf) begin
            nxt_word   = {neg_inf, EXP_TOP, {FRAC_W{1'b0}}};
            nxt_fl.inf = 1'b1;
        end else begin
            nxt_word = dp_word;
            nxt_fl   = dp_fl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_word;
                flags  <= nxt_fl;
            end
        end
    end
endmodule

// File: rtl/fpc_add_cluster_chk.sv
module fpc_add_cluster_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [4:0]  flags
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flags)));

    a_r8_nan_word: assert property (@(posedge clk) disable iff (rst)
        flags[4] |-> (result == 32'h7FC0_0000 && flags[3:0] == 4'b0000));

    a_r10_ovf_is_inf: assert property (@(posedge clk) disable iff (rst)
        flags[2] |-> (result[30:0] == 31'h7F80_0000 && flags[3]));

    a_r11_unf_is_zero: assert property (@(posedge clk) disable iff (rst)
        flags[1] |-> (result[30:0] == 31'h0 && !flags[3] && !flags[4]));

    a_r9_top_exp_flagged: assert property (@(posedge clk) disable iff (rst)
        (result[30:23] == 8'hFF) |-> (flags[3] || flags[4]));

    a_r9_special_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags[4:3]));
endmodule

bind fpc_add_cluster fpc_add_cluster_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags)
);

// File: tb/sim_fpc_add_cluster.sv
module sim_fpc_add_cluster;
    localparam int NOPS = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [NOPS*32-1:0] op_bus = '0;
    logic             out_valid;
    logic [31:0]      result;
    logic [4:0]       flags;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fpc_add_cluster #(.K(NOPS)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_bus(op_bus),
        .out_valid(out_valid), .result(result), .flags(flags)
    );

    function automatic logic [36:0] model(input logic [127:0] bus);
        logic nan_s = 0, pi = 0, ni = 0;
        int emax = 0, e, p;
        longint acc = 0, t, mg, n, s;
        logic neg, inx;
        for (int i = 0; i < NOPS; i++) begin
            logic [31:0] v = bus[i*32 +: 32];
            if (v[30:23] == 8'hFF) begin
                if (v[22:0] != 0) nan_s = 1;
                else if (v[31]) ni = 1;
                else pi = 1;
            end else if (v[30:23] != 0 && int'(v[30:23]) > emax) begin
                emax = int'(v[30:23]);
            end
        end
        if (nan_s || (pi && ni)) return {5'b10000, 32'h7FC00000};
        if (pi) return {5'b01000, 32'h7F800000};
        if (ni) return {5'b01000, 32'hFF800000};
        for (int i = 0; i < NOPS; i++) begin
            logic [31:0] v = bus[i*32 +: 32];
            if (v[30:23] != 0) begin
                e = emax - int'(v[30:23]);
                t = (e >= 27) ? 0 : ((longint'({1'b1, v[22:0]}) << 3) >> e);
                acc = v[31] ? acc - t : acc + t;
            end
        end
        if (acc == 0) return 37'd0;
        neg = acc < 0;
        mg  = neg ? -acc : acc;
        p = 0;
        for (int i = 0; i < 40; i++) if (((mg >> i) & 1) == 1) p = i;
        e = emax + p - 26;
        n = (p >= 26) ? (mg >> (p - 26)) : (mg << (26 - p));
        inx = (n & 7) != 0;
        s = (n >> 3) + (inx ? 1 : 0);
        if (s >= 64'd16777216) begin s = s >> 1; e = e + 1; end
        if (e >= 255) return {4'b0110, inx, neg, 8'hFF, 23'd0};
        if (e <= 0) return {4'b0001, inx, neg, 31'd0};
        return {4'b0000, inx, neg, e[7:0], s[22:0]};
    endfunction

    task automatic chk(input string req, input logic [36:0] act, input logic [36:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: flags/result actual %b/%h expected %b/%h",
                     req, act[36:32], act[31:0], exp_v[36:32], exp_v[31:0]);
        end
    endtask

    task automatic apply(input logic [31:0] a, b, c, d);
        @(negedge clk);
        op_bus   = {d, c, b, a};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic vec(input string req, input logic [31:0] a, b, c, d,
                       input logic [31:0] exp_r, input logic [4:0] exp_f);
        apply(a, b, c, d);
        chk(req, {flags, result}, {exp_f, exp_r});
        chk({req, " model"}, {flags, result}, model({d, c, b, a}));
    endtask

    task automatic t_reset;
        chk("R1 reset", {out_valid, flags, result}, 38'd0);
    endtask

    task automatic t_valid_hold;
        logic [31:0] keep;
        apply(32'h3F800000, 32'h3F800000, 0, 0);
        chk("R1 valid", {36'd0, out_valid}, 37'd1);
        keep = result;
        @(negedge clk);
        op_bus = {4{32'h40400000}};
        @(negedge clk);
        chk("R1 idle", {4'd0, out_valid, result}, {5'd0, keep});
    endtask

    task automatic t_basic;
        vec("R3 add two", 32'h3F800000, 32'h3F800000, 0, 0, 32'h40000000, 5'b00000);
        vec("R3 add four", 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000,
            32'h40800000, 5'b00000);
        vec("R4 negative sum", 32'hBF800000, 32'hBF800000, 0, 0, 32'hC0000000, 5'b00000);
        vec("R3 R4 growth", 32'h3FFFFFFF, 32'h3FFFFFFF, 32'h3FFFFFFF, 32'h3FFFFFFF,
            32'h40FFFFFF, 5'b00000);
        vec("R4 left shift", 32'h3FC00000, 32'hBF800000, 0, 0, 32'h3F000000, 5'b00000);
        vec("R7 cancel", 32'h3F800000, 32'hBF800000, 32'h40000000, 32'hC0000000,
            32'h00000000, 5'b00000);
    endtask

    task automatic t_align_round;
        vec("R2 far operand dropped", 32'h3F800000, 32'h30800000, 0, 0,
            32'h3F800000, 5'b00000);
        vec("R5 round up", 32'h3F800000, 32'h33800000, 0, 0, 32'h3F800001, 5'b00001);
        vec("R5 round away neg", 32'hBF800000, 32'hB3800000, 0, 0, 32'hBF800001, 5'b00001);
        vec("R6 round carry", 32'h3FFFFFFF, 32'h33800000, 0, 0, 32'h40000000, 5'b00001);
    endtask

    task automatic t_special;
        vec("R8 nan in", 32'h7FC00001, 32'h3F800000, 0, 0, 32'h7FC00000, 5'b10000);
        vec("R8 inf clash", 32'h7F800000, 32'hFF800000, 0, 0, 32'h7FC00000, 5'b10000);
        vec("R9 pos inf", 32'h7F800000, 32'hC2000000, 0, 0, 32'h7F800000, 5'b01000);
        vec("R9 neg inf", 32'hFF800000, 32'h3F800000, 0, 0, 32'hFF800000, 5'b01000);
        vec("R10 overflow", 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF,
            32'h7F800000, 5'b01100);
        vec("R11 underflow", 32'h00800001, 32'h80800000, 0, 0, 32'h00000000, 5'b00010);
        vec("R12 subnormals", 32'h00400000, 32'h00400000, 32'h80000001, 0,
            32'h00000000, 5'b00000);
        vec("R12 subnormal no max", 32'h00700000, 32'h3F800000, 0, 0,
            32'h3F800000, 5'b00000);
    endtask

    task automatic t_random;
        for (int n = 0; n < 60; n++) begin
            logic [31:0] v [NOPS];
            for (int i = 0; i < NOPS; i++) begin
                v[i] = {1'($urandom_range(0, 1)), 8'(120 + $urandom_range(0, 14)),
                        23'($urandom())};
                if ($urandom_range(0, 7) == 0) v[i] = 32'h0;
            end
            apply(v[0], v[1], v[2], v[3]);
            chk("R2 R5 random model", {flags, result}, model({v[3], v[2], v[1], v[0]}));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_valid_hold();
        t_basic();
        t_align_round();
        t_special();
        t_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule